// File: doc/BRIEF.md
# Two-Level Frame Serializer With Pin Mask

This block turns 32-bit data words into a paced bit stream on a 32-pin output bus. Time is counted in ticks of a reference clock-enable, not in system clocks. Two programmable values set the timing: the number of ticks each data bit is held, and the number of ticks in a whole frame. The data word leaves least significant bit first. Each data bit picks one of two 8-bit level bytes from a 16-bit level word. The chosen byte is ANDed with an 8-bit pin mask and placed on one of four 8-pin groups.

Frames arrive on a valid/ready stream port that carries the data word and the level word together. Back-pressure works as follows. While the serializer is idle, `in_ready` is high and the first frame is taken on any clock. Once the serializer is running, `in_ready` is high only in the clock where a reference tick ends the current frame. The producer therefore stalls until the next frame is needed, and the new frame starts with no gap. If nothing is valid at that boundary, the previous frame is replayed and a flag is raised.

Top module: `frame_serializer`

## Requirements
- R1: During and right after reset, `pins_out` and `pins_oe` are all zero, `in_ready` is 1, and `underrun` and `active` are 0.
- R2: While `active` is 0, `in_ready` is 1. While `active` is 1, `in_ready` is 1 only in a clock where `ref_tick` is 1 and that tick is the last tick of the current frame.
- R3: Data bits leave least significant bit first. Each bit is held for `bit_ticks` reference ticks. Bit index k of a frame is visible while the tick count within the frame lies in [k*bit_ticks, (k+1)*bit_ticks). The output changes only on clocks with `ref_tick` high or with a frame accepted.
- R4: A data bit of 0 selects `in_level[7:0]`. A data bit of 1 selects `in_level[15:8]`.
- R5: The selected byte, ANDed with `pin_mask`, appears on `pins_out[8*grp_sel +: 8]`, with bit k of the byte on the group's pin k. All other pins of `pins_out` are 0, and all pins are 0 while `active` is 0.
- R6: While active, `pins_oe[8*grp_sel +: 8]` equals `pin_mask` and every other `pins_oe` bit is 0. While inactive, `pins_oe` is 0.
- R7: A frame lasts `frame_ticks` reference ticks, counted from 0 after it is accepted. Bit positions at index 32 or above read as 0, so they select the low level byte.
- R8: If `in_valid` is 0 at the last tick of a frame, the last accepted data and level words start again from bit 0 and `underrun` becomes 1. `underrun` returns to 0 on the next accepted frame.
- R9: In the middle of a frame, `in_valid` has no effect. `in_ready` stays 0 and the output keeps following the current frame.
- R10: A `bit_ticks` or `frame_ticks` value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference clock-enable; timing advances only when high |
| bit_ticks | input | 16 | Reference ticks per data bit |
| frame_ticks | input | 16 | Reference ticks per frame |
| grp_sel | input | 2 | Selects the 8-pin group within the output bus |
| pin_mask | input | 8 | Pins of the selected group that are driven |
| in_valid | input | 1 | Producer has a frame |
| in_ready | output | 1 | Serializer takes a frame in this clock |
| in_data | input | 32 | Data word, sent least significant bit first |
| in_level | input | 16 | Level bytes: [7:0] for data 0, [15:8] for data 1 |
| pins_out | output | 32 | Output pin levels |
| pins_oe | output | 32 | Output enables, equal to the mask in the selected group |
| underrun | output | 1 | Last frame was replayed for lack of a new one |
| active | output | 1 | A frame is being serialized |

## Verification
The bench uses several timing settings:
- A single-tick bit with a frame of exactly 32 ticks, which exposes off-by-one errors in the shift step.
- Multi-tick bits, which separate holding a bit from shifting it.
- A frame longer than 32 bits, which shows whether the tail is zero-filled.
- A frame shorter than the word, which checks the early cut-off.
- Zero settings.

Random tick density and random producer gaps separate "advance on tick" from "advance every clock", and separate handshake acceptance from replay. Level words with distinct high and low bytes, together with masks such as a single bit, 0xFF and 0xA5, reveal swapped byte selection, a wrong group placement or a missing mask.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned PINS_PER_GRP = 8;
  localparam int unsigned NUM_GRP      = 4;
  localparam int unsigned GRP_SEL_W    = $clog2(NUM_GRP);

  typedef logic [PINS_PER_GRP-1:0] lvl_byte_t;

  typedef struct packed {
    lvl_byte_t one_lvl;
    lvl_byte_t zero_lvl;
  } lvl_pair_t;
endpackage

// File: rtl/fs_timer.sv
module fs_timer #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [TICK_W-1:0] bit_ticks,
  input  logic [TICK_W-1:0] frame_ticks,
  output logic              frame_last,
  output logic              bit_last
);
  logic [TICK_W-1:0] fcnt, bcnt;
  logic [TICK_W-1:0] bt_m1, ft_m1;

  // zero settings behave like one tick
  assign bt_m1 = (bit_ticks == '0) ? '0 : bit_ticks - 1'b1;
  assign ft_m1 = (frame_ticks == '0) ? '0 : frame_ticks - 1'b1;

  assign frame_last = (fcnt == ft_m1);
  assign bit_last   = (bcnt == bt_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= '0;
      bcnt <= '0;
    end else if (restart) begin
      fcnt <= '0;
      bcnt <= '0;
    end else if (advance) begin
      fcnt <= fcnt + 1'b1;
      bcnt <= bit_last ? '0 : bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              replay,
  input  logic              shift,
  input  logic [DATA_W-1:0] new_data,
  input  fs_pkg::lvl_pair_t new_lvl,
  output logic              cur_bit,
  output fs_pkg::lvl_pair_t cur_lvl
);
  logic [DATA_W-1:0] sh_q, keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      keep_q  <= '0;
      cur_lvl <= '0;
    end else if (load) begin
      sh_q    <= new_data;
      keep_q  <= new_data;
      cur_lvl <= new_lvl;
    end else if (replay) begin
      sh_q <= keep_q;
    end else if (shift) begin
      sh_q <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  assign cur_bit = sh_q[0];
endmodule

// File: rtl/fs_pinmap.sv
module fs_pinmap
  import fs_pkg::*;
(
  input  logic                 en,
  input  logic                 bit_val,
  input  lvl_pair_t            lvl,
  input  logic [GRP_SEL_W-1:0] grp_sel,
  input  lvl_byte_t            mask,
  output logic [PINS_PER_GRP*NUM_GRP-1:0] pins,
  output logic [PINS_PER_GRP*NUM_GRP-1:0] oe
);
  lvl_byte_t sel_byte;
  assign sel_byte = bit_val ? lvl.one_lvl : lvl.zero_lvl;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = en && (grp_sel == GRP_SEL_W'(g));
    assign pins[g*PINS_PER_GRP +: PINS_PER_GRP] = hit ? (sel_byte & mask) : '0;
    assign oe[g*PINS_PER_GRP +: PINS_PER_GRP]   = hit ? mask : '0;
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import fs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TICK_W = 16,
  localparam int unsigned LVL_W = 2 * PINS_PER_GRP,
  localparam int unsigned BUS_W = PINS_PER_GRP * NUM_GRP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic [TICK_W-1:0]       bit_ticks,
  input  logic [TICK_W-1:0]       frame_ticks,
  input  logic [GRP_SEL_W-1:0]    grp_sel,
  input  logic [PINS_PER_GRP-1:0] pin_mask,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DATA_W-1:0]       in_data,
  input  logic [LVL_W-1:0]        in_level,
  output logic [BUS_W-1:0]        pins_out,
  output logic [BUS_W-1:0]        pins_oe,
  output logic                    underrun,
  output logic                    active
);
  logic frame_last, bit_last;
  logic frame_end, take, replay, step, shift;
  logic cur_bit;
  lvl_pair_t cur_lvl;

  assign frame_end = active && ref_tick && frame_last;
  assign in_ready  = !active || frame_end;
  assign take      = in_valid && in_ready;
  assign replay    = frame_end && !in_valid;
  assign step      = active && ref_tick && !frame_end;
  assign shift     = step && bit_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      underrun <= 1'b0;
    end else if (take) begin
      active   <= 1'b1;
      underrun <= 1'b0;
    end else if (replay) begin
      underrun <= 1'b1;
    end
  end

  fs_timer #(.TICK_W(TICK_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (take || replay),
    .advance     (step),
    .bit_ticks   (bit_ticks),
    .frame_ticks (frame_ticks),
    .frame_last  (frame_last),
    .bit_last    (bit_last)
  );

  fs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .replay   (replay),
    .shift    (shift),
    .new_data (in_data),
    .new_lvl  (lvl_pair_t'(in_level)),
    .cur_bit  (cur_bit),
    .cur_lvl  (cur_lvl)
  );

  fs_pinmap u_map (
    .en      (active),
    .bit_val (cur_bit),
    .lvl     (cur_lvl),
    .grp_sel (grp_sel),
    .mask    (pin_mask),
    .pins    (pins_out),
    .oe      (pins_oe)
  );
endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_tick,
  input logic [1:0]  grp_sel,
  input logic [7:0]  pin_mask,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] pins_out,
  input logic [31:0] pins_oe,
  input logic        underrun,
  input logic        active
);
  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> in_ready);

  p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_ready) |-> ref_tick);

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ref_tick) |=>
      ($stable(pins_out) || !$stable(pin_mask) || !$stable(grp_sel)));

  p_drive_inside_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_out & ~pins_oe) == 32'h0);

  p_oe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(pins_oe) == $countones(pin_mask)));

  p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(active) && !$past(in_valid)));
endmodule

bind frame_serializer frame_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_tick (ref_tick),
  .grp_sel  (grp_sel),
  .pin_mask (pin_mask),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .pins_out (pins_out),
  .pins_oe  (pins_oe),
  .underrun (underrun),
  .active   (active)
);

// File: tb/frame_serializer_tb.sv
module frame_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [15:0] bit_ticks = 16'd1, frame_ticks = 16'd32;
  logic [1:0]  grp_sel = 2'd0;
  logic [7:0]  pin_mask = 8'h01;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [15:0] in_level = '0;
  logic [31:0] pins_out, pins_oe;
  logic        underrun, active;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  bit          m_run, m_und;
  logic [31:0] m_data;
  logic [15:0] m_lvl;
  int          m_t;
  int          n_under, n_take;

  always #2 clk = ~clk;

  frame_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bit_ticks(bit_ticks),
    .frame_ticks(frame_ticks), .grp_sel(grp_sel), .pin_mask(pin_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_level(in_level), .pins_out(pins_out), .pins_oe(pins_oe),
    .underrun(underrun), .active(active)
  );

  function automatic int eff(input logic [15:0] v);
    return (v == 16'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [31:0] exp_pins();
    int idx;
    logic b;
    logic [7:0] byt;
    logic [31:0] r;
    if (!m_run) return 32'h0;
    idx = m_t / eff(bit_ticks);
    b   = (idx < 32) ? m_data[idx] : 1'b0;
    byt = b ? m_lvl[15:8] : m_lvl[7:0];
    r = '0;
    r[grp_sel*8 +: 8] = byt & pin_mask;
    return r;
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] r;
    r = '0;
    if (m_run) r[grp_sel*8 +: 8] = pin_mask;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", pins_out, 32'h0);
    rst_n = 1'b1;
    m_run = 0; m_und = 0; m_t = 0; m_data = '0; m_lvl = '0;
    @(negedge clk);
    chk("R1 pins_out after reset", pins_out, 32'h0);
    chk("R1 pins_oe after reset", pins_oe, 32'h0);
    chk("R1 ready after reset", {31'h0, in_ready}, 32'h1);
    chk("R1 underrun/active after reset", {30'h0, underrun, active}, 32'h0);
  endtask

  // one clock: check state, drive inputs, check ready, advance model
  task automatic step(input int tick_pct, input int valid_pct);
    bit rdy;
    chk("R3 R4 R5 R7 R10 pins_out", pins_out, exp_pins());
    chk("R6 pins_oe", pins_oe, exp_oe());
    chk("R8 underrun", {31'h0, underrun}, {31'h0, m_und});
    chk("R2 active", {31'h0, active}, {31'h0, m_run});
    ref_tick = ($urandom_range(99) < tick_pct);
    in_valid = ($urandom_range(99) < valid_pct);
    in_data  = $urandom;
    in_level = 16'($urandom);
    #1;
    rdy = !m_run || (ref_tick && (m_t == eff(frame_ticks) - 1));
    chk("R2 R9 in_ready", {31'h0, in_ready}, {31'h0, rdy});
    if (rdy && in_valid) begin
      m_run = 1; m_data = in_data; m_lvl = in_level; m_t = 0; m_und = 0; n_take++;
    end else if (m_run && ref_tick) begin
      if (m_t == eff(frame_ticks) - 1) begin
        m_t = 0; m_und = 1; n_under++;
      end else m_t++;
    end
    @(negedge clk);
  endtask

  task automatic phase(input int bt, input int ft, input int g, input int mk,
                       input int cycles, input int tpct, input int vpct);
    bit_ticks = 16'(bt); frame_ticks = 16'(ft);
    grp_sel = 2'(g); pin_mask = 8'(mk);
    do_reset();
    for (int i = 0; i < cycles; i++) step(tpct, vpct);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    n_under = 0; n_take = 0;
    @(negedge clk);
    phase(1, 32, 0, 8'hFF, 3000, 100, 90);   // R3 single-tick bits, exact word
    phase(3, 96, 2, 8'h01, 6000, 60, 50);    // R3 held bits, one serial line
    phase(2, 80, 3, 8'hA5, 6000, 70, 40);    // R7 40 bits: tail zero-filled
    phase(5, 20, 1, 8'h3C, 4000, 50, 60);    // R7 short frame
    phase(0, 0, 1, 8'hF0, 2000, 80, 50);     // R10 zero settings
    // directed R8: starve producer after one frame
    phase(1, 8, 0, 8'hFF, 1, 100, 100);
    for (int i = 0; i < 20; i++) step(100, 0);
    chk("R8 underrun after starved boundary", {31'h0, underrun}, 32'h1);
    // directed R9: valid held mid-frame with no ticks
    phase(4, 40, 2, 8'h0F, 1, 100, 100);
    for (int i = 0; i < 30; i++) step(0, 100);
    chk("R9 still active, no acceptance", {31'h0, active, in_ready}, 32'h2);
    chk("R8 R2 coverage underrun seen", {31'h0, n_under > 0}, 32'h1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule